// File: doc/BRIEF.md
# Socket Receive Drain Engine

This block empties one socket's circular receive buffer, held inside an external network controller, into a local byte FIFO. It works through a request/response access port that an SPI master serves. The port carries register reads, register writes, command writes and burst reads. A single `start` pulse runs one pass. The pass reads the pending byte count and stops early if nothing is waiting. Otherwise it reads the socket's 16-bit read pointer and sizes the pass from three limits: the pending count, a fixed chunk cap and the free space in the local FIFO. It then streams the bytes out, splitting the burst where the buffer region ends. It writes the advanced pointer back, issues the receive-acknowledge command and polls the command register until the controller clears it.

The burst bytes come in on a valid/ready stream from the SPI master and leave on a valid/ready stream toward the FIFO. They pass through with no storage. `out_valid` follows `bst_valid` and `bst_ready` follows `out_ready`, but only while a burst segment is active. A FIFO that holds `out_ready` low therefore stalls the SPI master byte by byte, and no byte is lost or repeated. On the access port, the engine holds each request stable until `acc_ready` is seen and keeps only one request outstanding. Register reads, register writes and command writes each end with one `rsp_valid` pulse. A burst read ends when its byte count has been delivered.

The caller chooses which socket to serve and when to call the engine. The parameters set the register addresses, the buffer base, the region size and the chunk cap.

Top module: `rxdrain_engine`

## Requirements
- R1: After `start`, the first access is a register read (acc_kind 0) of the pending-size address. If that read returns zero, the engine makes no further access, pulses `done` with `moved_len` = 0 and forwards no bytes.
- R2: When the pending size is non-zero, the second access is a register read (acc_kind 0) of the read-pointer address.
- R3: The physical offset is the pointer ANDed with REGION−1. The first burst read (acc_kind 2) starts at BUF_BASE + offset.
- R4: When offset + pass length exceeds REGION, the pass uses two bursts. The first covers REGION − offset bytes. The second starts at BUF_BASE and covers the rest. No burst ever crosses the region end.
- R5: The pass length is the smallest of the pending size, CHUNK and `fifo_free`. It is reported on `moved_len` together with `done`.
- R6: While `fifo_free` is zero after the pointer read, the engine waits without issuing any access, and the pointer stays untouched.
- R7: After the data, the engine does a register write (acc_kind 1) to the read-pointer address with the pointer plus the pass length, modulo 65536.
- R8: After the pointer write completes, the engine does a command write (acc_kind 3) of CMD_RECV to the command address.
- R9: The engine then reads the command address (acc_kind 0) until a read returns zero. After that it gives a `done` pulse one cycle wide, with `busy` low.
- R10: The bytes appear on `out_data` in buffer order. A byte transfers only when `bst_valid` and `out_ready` are both high during a burst.
- R11: Once `acc_valid` is raised, it stays high and kind, address, length and write data stay unchanged until `acc_ready` is seen.
- R12: Out of reset the engine is idle, with `busy`, `done`, `acc_valid` and `out_valid` low. A `start` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one drain pass (ignored while busy) |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| moved_len | output | W | Bytes moved by the last pass, valid with `done` |
| fifo_free | input | W | Free byte slots in the local FIFO |
| acc_valid | output | 1 | Access request valid |
| acc_ready | input | 1 | Access request accepted |
| acc_kind | output | 2 | 0 register read, 1 register write, 2 burst read, 3 command write |
| acc_addr | output | W | Register or buffer address |
| acc_len | output | W | Burst byte count (kind 2) |
| acc_wdata | output | W | Write data (kinds 1 and 3) |
| rsp_valid | input | 1 | Completion of a read, write or command access |
| rsp_data | input | W | Read data, valid with `rsp_valid` |
| bst_valid | input | 1 | Burst byte valid from the SPI master |
| bst_ready | output | 1 | Burst byte taken |
| bst_data | input | 8 | Burst byte |
| out_valid | output | 1 | Byte valid toward the FIFO |
| out_ready | input | 1 | FIFO accepts the byte |
| out_data | output | 8 | Byte toward the FIFO |

## Verification
The bench builds the engine with REGION = 256 and CHUNK = 100 instead of the 2048-byte region and the 1460-byte cap. With these values, random 16-bit pointers often land close enough to the region end to force a split burst. Random pending counts above 100 hit the chunk cap on many passes, and each pass stays a few hundred cycles long. The pointer width stays at 16, so directed pointers near 0xFFFF cover the write-back rolling over to zero, both where the pass ends exactly at the region end and where it splits.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic [1:0] {
    ACC_RD    = 2'd0,
    ACC_WR    = 2'd1,
    ACC_BURST = 2'd2,
    ACC_CMD   = 2'd3
  } acc_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SIZE_REQ,
    ST_SIZE_RSP,
    ST_PTR_REQ,
    ST_PTR_RSP,
    ST_SPACE,
    ST_SEG1_REQ,
    ST_SEG1_DAT,
    ST_SEG2_REQ,
    ST_SEG2_DAT,
    ST_PWR_REQ,
    ST_PWR_RSP,
    ST_CMD_REQ,
    ST_CMD_RSP,
    ST_POLL_REQ,
    ST_POLL_RSP
  } drain_st_e;

endpackage

// File: rtl/rxd_len_calc.sv
// Sizes a pass and splits it at the region end.
module rxd_len_calc #(
  parameter int W      = 16,
  parameter int REGION = 2048,
  parameter int CHUNK  = 1460
) (
  input  logic [W-1:0] pending,
  input  logic [W-1:0] ptr,
  input  logic [W-1:0] free,
  output logic [W-1:0] pass_len,
  output logic [W-1:0] seg1_len,
  output logic [W-1:0] seg2_len,
  output logic [W-1:0] offset
);
  localparam logic [W-1:0] MASK = W'(REGION - 1);
  localparam logic [W-1:0] RGN  = W'(REGION);
  localparam logic [W-1:0] CAP  = W'(CHUNK);

  logic [W-1:0] capped;
  logic [W-1:0] room;

  always_comb begin
    capped   = (pending < CAP) ? pending : CAP;
    pass_len = (free < capped) ? free : capped;
    offset   = ptr & MASK;
    room     = RGN - offset;
    seg1_len = (pass_len < room) ? pass_len : room;
    seg2_len = pass_len - seg1_len;
  end
endmodule

// File: rtl/rxd_burst_ctr.sv
// Counts the bytes left in the active burst segment.
module rxd_burst_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_len,
  input  logic         beat,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= load_len;
    else if (beat && cnt != '0) cnt <= cnt - W'(1);
  end

  assign last = (cnt == W'(1));
endmodule

// File: rtl/rxd_seq.sv
// Pass sequencer: size read, pointer read, bursts, write-back, command, poll.
module rxd_seq
  import rxd_pkg::*;
#(
  parameter int           W        = 16,
  parameter logic [W-1:0] REG_SIZE = 'h0010,
  parameter logic [W-1:0] REG_RPTR = 'h0012,
  parameter logic [W-1:0] REG_CMD  = 'h0002,
  parameter logic [W-1:0] CMD_RECV = 'h0040,
  parameter logic [W-1:0] BUF_BASE = 'h8000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         acc_ready,
  input  logic         rsp_valid,
  input  logic [W-1:0] rsp_data,
  input  logic         beat,
  input  logic         seg_last,
  input  logic [W-1:0] plan_len,
  input  logic [W-1:0] plan_seg1,
  input  logic [W-1:0] plan_seg2,
  input  logic [W-1:0] plan_off,
  output logic [W-1:0] pending_q,
  output logic [W-1:0] ptr_q,
  output logic         seg_load,
  output logic [W-1:0] seg_load_len,
  output logic         in_data,
  output logic         acc_valid,
  output acc_kind_e    acc_kind,
  output logic [W-1:0] acc_addr,
  output logic [W-1:0] acc_len,
  output logic [W-1:0] acc_wdata,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] moved_len
);
  drain_st_e    st, nxt;
  logic [W-1:0] len_q, seg1_q, seg2_q, off_q;
  logic         rsp_zero;

  assign rsp_zero = (rsp_data == '0);

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:     if (start)           nxt = ST_SIZE_REQ;
      ST_SIZE_REQ: if (acc_ready)       nxt = ST_SIZE_RSP;
      ST_SIZE_RSP: if (rsp_valid)       nxt = rsp_zero ? ST_IDLE : ST_PTR_REQ;
      ST_PTR_REQ:  if (acc_ready)       nxt = ST_PTR_RSP;
      ST_PTR_RSP:  if (rsp_valid)       nxt = ST_SPACE;
      ST_SPACE:    if (plan_len != '0)  nxt = ST_SEG1_REQ;
      ST_SEG1_REQ: if (acc_ready)       nxt = ST_SEG1_DAT;
      ST_SEG1_DAT: if (beat && seg_last) nxt = (seg2_q != '0) ? ST_SEG2_REQ : ST_PWR_REQ;
      ST_SEG2_REQ: if (acc_ready)       nxt = ST_SEG2_DAT;
      ST_SEG2_DAT: if (beat && seg_last) nxt = ST_PWR_REQ;
      ST_PWR_REQ:  if (acc_ready)       nxt = ST_PWR_RSP;
      ST_PWR_RSP:  if (rsp_valid)       nxt = ST_CMD_REQ;
      ST_CMD_REQ:  if (acc_ready)       nxt = ST_CMD_RSP;
      ST_CMD_RSP:  if (rsp_valid)       nxt = ST_POLL_REQ;
      ST_POLL_REQ: if (acc_ready)       nxt = ST_POLL_RSP;
      ST_POLL_RSP: if (rsp_valid)       nxt = rsp_zero ? ST_IDLE : ST_POLL_REQ;
      default:                          nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pending_q <= '0;
      ptr_q     <= '0;
      len_q     <= '0;
      seg1_q    <= '0;
      seg2_q    <= '0;
      off_q     <= '0;
      done      <= 1'b0;
      moved_len <= '0;
    end else begin
      st   <= nxt;
      done <= 1'b0;
      if (st == ST_SIZE_RSP && rsp_valid) begin
        pending_q <= rsp_data;
        if (rsp_zero) begin
          done      <= 1'b1;
          moved_len <= '0;
        end
      end
      if (st == ST_PTR_RSP && rsp_valid) ptr_q <= rsp_data;
      if (st == ST_SPACE && plan_len != '0) begin
        len_q  <= plan_len;
        seg1_q <= plan_seg1;
        seg2_q <= plan_seg2;
        off_q  <= plan_off;
      end
      if (st == ST_POLL_RSP && rsp_valid && rsp_zero) begin
        done      <= 1'b1;
        moved_len <= len_q;
      end
    end
  end

  always_comb begin
    acc_valid = 1'b0;
    acc_kind  = ACC_RD;
    acc_addr  = '0;
    acc_len   = '0;
    acc_wdata = '0;
    unique case (st)
      ST_SIZE_REQ: begin acc_valid = 1'b1; acc_addr = REG_SIZE; end
      ST_PTR_REQ:  begin acc_valid = 1'b1; acc_addr = REG_RPTR; end
      ST_SEG1_REQ: begin
        acc_valid = 1'b1; acc_kind = ACC_BURST;
        acc_addr  = BUF_BASE + off_q; acc_len = seg1_q;
      end
      ST_SEG2_REQ: begin
        acc_valid = 1'b1; acc_kind = ACC_BURST;
        acc_addr  = BUF_BASE; acc_len = seg2_q;
      end
      ST_PWR_REQ: begin
        acc_valid = 1'b1; acc_kind = ACC_WR;
        acc_addr  = REG_RPTR; acc_wdata = ptr_q + len_q;
      end
      ST_CMD_REQ: begin
        acc_valid = 1'b1; acc_kind = ACC_CMD;
        acc_addr  = REG_CMD; acc_wdata = CMD_RECV;
      end
      ST_POLL_REQ: begin acc_valid = 1'b1; acc_addr = REG_CMD; end
      default: ;
    endcase
  end

  assign seg_load     = (st == ST_SEG1_REQ || st == ST_SEG2_REQ) && acc_ready;
  assign seg_load_len = (st == ST_SEG2_REQ) ? seg2_q : seg1_q;
  assign in_data      = (st == ST_SEG1_DAT) || (st == ST_SEG2_DAT);
  assign busy         = (st != ST_IDLE);
endmodule

// File: rtl/rxdrain_engine.sv
module rxdrain_engine
  import rxd_pkg::*;
#(
  parameter int           W        = 16,
  parameter int           REGION   = 2048,
  parameter int           CHUNK    = 1460,
  parameter logic [W-1:0] REG_SIZE = 'h0010,
  parameter logic [W-1:0] REG_RPTR = 'h0012,
  parameter logic [W-1:0] REG_CMD  = 'h0002,
  parameter logic [W-1:0] CMD_RECV = 'h0040,
  parameter logic [W-1:0] BUF_BASE = 'h8000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] moved_len,
  input  logic [W-1:0] fifo_free,
  output logic         acc_valid,
  input  logic         acc_ready,
  output logic [1:0]   acc_kind,
  output logic [W-1:0] acc_addr,
  output logic [W-1:0] acc_len,
  output logic [W-1:0] acc_wdata,
  input  logic         rsp_valid,
  input  logic [W-1:0] rsp_data,
  input  logic         bst_valid,
  output logic         bst_ready,
  input  logic [7:0]   bst_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [7:0]   out_data
);
  logic [W-1:0] pending_q, ptr_q;
  logic [W-1:0] plan_len, plan_seg1, plan_seg2, plan_off;
  logic         seg_load, seg_last, in_data, beat;
  logic [W-1:0] seg_load_len;
  acc_kind_e    kind_e;

  rxd_len_calc #(.W(W), .REGION(REGION), .CHUNK(CHUNK)) u_calc (
    .pending (pending_q),
    .ptr     (ptr_q),
    .free    (fifo_free),
    .pass_len(plan_len),
    .seg1_len(plan_seg1),
    .seg2_len(plan_seg2),
    .offset  (plan_off)
  );

  rxd_burst_ctr #(.W(W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (seg_load),
    .load_len(seg_load_len),
    .beat    (beat),
    .last    (seg_last)
  );

  rxd_seq #(
    .W(W), .REG_SIZE(REG_SIZE), .REG_RPTR(REG_RPTR), .REG_CMD(REG_CMD),
    .CMD_RECV(CMD_RECV), .BUF_BASE(BUF_BASE)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .acc_ready   (acc_ready),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .beat        (beat),
    .seg_last    (seg_last),
    .plan_len    (plan_len),
    .plan_seg1   (plan_seg1),
    .plan_seg2   (plan_seg2),
    .plan_off    (plan_off),
    .pending_q   (pending_q),
    .ptr_q       (ptr_q),
    .seg_load    (seg_load),
    .seg_load_len(seg_load_len),
    .in_data     (in_data),
    .acc_valid   (acc_valid),
    .acc_kind    (kind_e),
    .acc_addr    (acc_addr),
    .acc_len     (acc_len),
    .acc_wdata   (acc_wdata),
    .busy        (busy),
    .done        (done),
    .moved_len   (moved_len)
  );

  assign acc_kind  = kind_e;
  assign out_valid = bst_valid & in_data;
  assign bst_ready = out_ready & in_data;
  assign out_data  = bst_data;
  assign beat      = bst_valid & out_ready & in_data;
endmodule

// File: rtl/rxd_chk.sv
module rxd_chk #(
  parameter int           W        = 16,
  parameter int           REGION   = 2048,
  parameter int           CHUNK    = 1460,
  parameter logic [W-1:0] BUF_BASE = 'h8000
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic         acc_valid,
  input logic         acc_ready,
  input logic [1:0]   acc_kind,
  input logic [W-1:0] acc_addr,
  input logic [W-1:0] acc_len,
  input logic [W-1:0] acc_wdata,
  input logic         bst_ready,
  input logic         out_valid
);
  logic         is_burst;
  logic [W:0]   burst_end;

  assign is_burst  = acc_valid && (acc_kind == 2'd2);
  assign burst_end = {1'b0, acc_addr - BUF_BASE} + {1'b0, acc_len};

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_ready |=> acc_valid && $stable(acc_kind) && $stable(acc_addr)
      && $stable(acc_len) && $stable(acc_wdata)); // R11

  AST_BURST_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    is_burst |-> burst_end <= (W+1)'(REGION)); // R4

  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    is_burst |-> (acc_len <= W'(CHUNK)) && (acc_len != '0)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !acc_valid && !out_valid && !bst_ready); // R12
endmodule

bind rxdrain_engine rxd_chk #(
  .W(W), .REGION(REGION), .CHUNK(CHUNK), .BUF_BASE(BUF_BASE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .acc_valid(acc_valid),
  .acc_ready(acc_ready),
  .acc_kind (acc_kind),
  .acc_addr (acc_addr),
  .acc_len  (acc_len),
  .acc_wdata(acc_wdata),
  .bst_ready(bst_ready),
  .out_valid(out_valid)
);

// File: tb/rxdrain_engine_tb_top.sv
`timescale 1ns/1ps
module rxdrain_engine_tb_top;
  localparam int W = 16, REGION = 256, CHUNK = 100;
  localparam logic [15:0] A_SIZE = 16'h0010, A_RPTR = 16'h0012, A_CMD = 16'h0002;
  localparam logic [15:0] V_RECV = 16'h0040, A_BUF = 16'h8000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic start = 0, busy, done;
  logic [15:0] moved_len, fifo_free = 16'hFFFF;
  logic acc_valid, acc_ready = 0;
  logic [1:0] acc_kind;
  logic [15:0] acc_addr, acc_len, acc_wdata;
  logic rsp_valid = 0; logic [15:0] rsp_data = 0;
  logic bst_valid = 0, bst_ready; logic [7:0] bst_data = 0;
  logic out_valid, out_ready = 0; logic [7:0] out_data;

  rxdrain_engine #(.W(W), .REGION(REGION), .CHUNK(CHUNK), .REG_SIZE(A_SIZE),
    .REG_RPTR(A_RPTR), .REG_CMD(A_CMD), .CMD_RECV(V_RECV), .BUF_BASE(A_BUF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .moved_len(moved_len), .fifo_free(fifo_free), .acc_valid(acc_valid),
    .acc_ready(acc_ready), .acc_kind(acc_kind), .acc_addr(acc_addr),
    .acc_len(acc_len), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .bst_valid(bst_valid), .bst_ready(bst_ready),
    .bst_data(bst_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data));

  int checks = 0, fails = 0;
  logic [15:0] m_size, m_ptr;
  int m_polls_cfg = 0, m_polls_left = 0, salt = 0;
  int lg_n = 0;
  logic [1:0]  lg_kind [16];
  logic [15:0] lg_addr [16], lg_len [16], lg_wd [16];
  logic [7:0]  rx_b [256];
  int rx_n = 0;

  function automatic logic [7:0] byte_at(input logic [15:0] a);
    return 8'(int'(a) * 29 + salt);
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Byte sink with random back-pressure.
  initial forever begin
    @(negedge clk);
    #2 out_ready = ($urandom % 4) != 0;
    #3 if (out_valid && out_ready) begin
      if (rx_n < 256) rx_b[rx_n] = out_data;
      rx_n++;
    end
  end

  // Controller and SPI master model.
  initial forever begin
    @(negedge clk);
    if (acc_valid) begin
      logic [1:0] k; logic [15:0] a, l, wd;
      k = acc_kind; a = acc_addr; l = acc_len; wd = acc_wdata;
      acc_ready = 1;
      @(negedge clk);
      acc_ready = 0;
      if (lg_n < 16) begin
        lg_kind[lg_n] = k; lg_addr[lg_n] = a; lg_len[lg_n] = l; lg_wd[lg_n] = wd;
      end
      lg_n++;
      if (k == 2'd2) begin
        for (int i = 0; i < int'(l); i++) begin
          bst_data = byte_at(a + 16'(i));
          bst_valid = 1;
          #5;
          while (!bst_ready) begin @(negedge clk); #5; end
          @(negedge clk);
          if ($urandom % 5 == 0) begin bst_valid = 0; @(negedge clk); end
        end
        bst_valid = 0;
      end else begin
        repeat ($urandom % 3) @(negedge clk);
        if (k == 2'd0) begin
          if (a == A_SIZE) rsp_data = m_size;
          else if (a == A_RPTR) rsp_data = m_ptr;
          else if (a == A_CMD) begin
            if (m_polls_left > 0) begin rsp_data = V_RECV; m_polls_left--; end
            else rsp_data = 16'h0;
          end else rsp_data = 16'hDEAD;
        end else if (k == 2'd1) begin
          if (a == A_RPTR) m_ptr = wd;
        end else begin
          m_polls_left = m_polls_cfg;
        end
        rsp_valid = 1;
        @(negedge clk);
        rsp_valid = 0;
      end
    end
  end

  task automatic run_pass(input logic [15:0] ptr, input logic [15:0] size,
                          input logic [15:0] free, input int polls,
                          input bit hold_free, input bit mid_start);
    int exp_len, off, s1, s2, idx, n_done;
    logic [15:0] mv;
    bit ok;
    m_ptr = ptr; m_size = size; m_polls_cfg = polls; m_polls_left = 0;
    salt = int'($urandom % 256); lg_n = 0; rx_n = 0;
    fifo_free = hold_free ? 16'h0 : free;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    if (hold_free) begin
      while (lg_n < 2) @(negedge clk);
      repeat (30) @(negedge clk);
      chk(lg_n == 2 && !acc_valid && rx_n == 0, "R6 no access while FIFO full", lg_n, 2);
      fifo_free = free;
    end
    if (mid_start) begin
      repeat (3) @(negedge clk); start = 1; @(negedge clk); start = 0;
    end
    while (!done) @(negedge clk);
    mv = moved_len; n_done = lg_n;
    repeat (8) @(negedge clk);
    if (mid_start) chk(!busy && lg_n == n_done, "R12 start ignored while busy", lg_n, n_done);

    chk(lg_kind[0] == 2'd0 && lg_addr[0] == A_SIZE, "R1 first access size read",
        int'(lg_addr[0]), int'(A_SIZE));
    if (size == 0) begin
      chk(lg_n == 1 && mv == 0 && rx_n == 0, "R1 zero pending exits", lg_n, 1);
      return;
    end
    exp_len = imin(imin(int'(size), CHUNK), int'(free));
    off = int'(ptr) & (REGION - 1);
    s1 = imin(exp_len, REGION - off);
    s2 = exp_len - s1;
    chk(lg_kind[1] == 2'd0 && lg_addr[1] == A_RPTR, "R2 pointer read",
        int'(lg_addr[1]), int'(A_RPTR));
    chk(lg_kind[2] == 2'd2 && lg_addr[2] == A_BUF + 16'(off) && int'(lg_len[2]) == s1,
        "R3 first burst addr", int'(lg_addr[2]), int'(A_BUF) + off);
    idx = 3;
    if (s2 != 0) begin
      chk(lg_kind[3] == 2'd2 && lg_addr[3] == A_BUF && int'(lg_len[3]) == s2,
          "R4 wrap burst len", int'(lg_len[3]), s2);
      idx = 4;
    end
    chk(lg_kind[idx] == 2'd1 && lg_addr[idx] == A_RPTR && lg_wd[idx] == ptr + 16'(exp_len),
        "R7 pointer write-back", int'(lg_wd[idx]), int'(ptr + 16'(exp_len)));
    chk(lg_kind[idx+1] == 2'd3 && lg_addr[idx+1] == A_CMD && lg_wd[idx+1] == V_RECV,
        "R8 receive command", int'(lg_wd[idx+1]), int'(V_RECV));
    ok = (lg_n == idx + 3 + polls);
    for (int p = idx + 2; p < lg_n && p < 16; p++)
      if (lg_kind[p] != 2'd0 || lg_addr[p] != A_CMD) ok = 0;
    chk(ok, "R9 poll until clear", lg_n, idx + 3 + polls);
    chk(int'(mv) == exp_len, "R5 pass length", int'(mv), exp_len);
    ok = (rx_n == exp_len);
    for (int b = 0; b < exp_len && b < 256; b++)
      if (rx_b[b] != byte_at(A_BUF + ((ptr + 16'(b)) & 16'(REGION - 1)))) ok = 0;
    chk(ok, "R10 byte stream", rx_n, exp_len);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7411));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !acc_valid && !out_valid, "R12 reset idle", int'(busy), 0);
    run_pass(16'h0000, 16'd0,    16'hFFFF, 0, 0, 0);  // R1 zero pending
    run_pass(16'h0000, 16'd50,   16'hFFFF, 1, 0, 0);  // plain
    run_pass(16'h00F0, 16'd40,   16'hFFFF, 2, 0, 0);  // R4 split 16+24
    run_pass(16'hFFE0, 16'd32,   16'hFFFF, 0, 0, 0);  // ends on region end, R7 wrap
    run_pass(16'hFFF8, 16'd90,   16'hFFFF, 3, 0, 0);  // R4 split, R7 wrap
    run_pass(16'h1234, 16'd1000, 16'hFFFF, 1, 0, 0);  // R5 chunk cap
    run_pass(16'h0421, 16'd50,   16'd7,    0, 0, 0);  // R5 FIFO limit
    run_pass(16'h00FA, 16'd60,   16'd20,   1, 1, 0);  // R6 wait then split
    run_pass(16'h0300, 16'd80,   16'hFFFF, 2, 0, 1);  // R12 start ignored
    for (int n = 0; n < 40; n++) begin
      logic [15:0] p, s, f;
      p = 16'($urandom);
      s = ($urandom % 6 == 0) ? 16'd0 : 16'(1 + $urandom % 300);
      f = ($urandom % 2 == 0) ? 16'(1 + $urandom % 120) : 16'hFFFF;
      run_pass(p, s, f, int'($urandom % 4), 0, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule